// File: doc/BRIEF.md
# DMA Channel Request and Completion Interrupt Controller

This block stands between the peripherals that request DMA work and the sequencer that performs it, and also between that sequencer and the CPU. On the request side it watches one external request line per channel and latches every rising edge into a per-channel flag. A flag becomes a channel trigger only when software has enabled that channel. Software can also start any channel directly by writing a one to a manual-start register. This path ignores both the flag and the enable. Triggers leave the block one per cycle on a registered `trig_valid`/`trig_chan` pair. When several channels are ready at once, the lowest channel number goes first.

On the completion side the sequencer reports a completion code, together with a flag that says whether the finished transfer wants an interrupt. The code selects a pending bit. Which channel produced the code does not matter. The pending bits are masked by an interrupt-enable register, and their OR drives one registered interrupt line. Software clears pending bits by writing ones. The 64-bit registers appear on a 32-bit bus as a low word and a high word.

The bus uses 4-bit word addresses. The address is {group[2:0], half}, where half=0 selects channels 0..31 and half=1 selects channels 32..63. The groups are:

| Group | Register | Access |
|---|---|---|
| 0 | request flags | read only |
| 1 | channel enable | read/write |
| 2 | manual start | write-one, reads as 0 |
| 3 | missed request | read, write-one-to-clear |
| 4 | pending | read only |
| 5 | interrupt enable | read/write |
| 6 | pending clear | write-one, reads as 0 |

Reads are registered, so read data appears one cycle after the address is presented.

Top module: `dma_evt_irq_ctrl`

## Requirements
- R1: A rising edge on `evt_in[n]` sets request flag n (group 0) on the next clock, whether or not channel n is enabled. A line that is held high sets the flag once only.
- R2: A set request flag produces a trigger for its channel only while enable bit n (group 1) is 1. A flag on a disabled channel stays set and produces no trigger.
- R3: Writing 1 to bit n of the manual-start register (group 2) produces one trigger for channel n, whatever the enable and flag bits are. It leaves the flag of channel n unchanged.
- R4: Channel n of 32 or above is held at bit n-32 of the high word (half=1) of every group. Channel n below 32 is held at bit n of the low word (half=0).
- R5: A cycle with `cmpl_valid`=1 and `cmpl_ie`=1 sets pending bit `cmpl_code` (group 4) on the next clock. When `cmpl_ie`=0 the completion changes no pending bit.
- R6: `irq_out` is 1 exactly when some pending bit and its interrupt-enable bit (group 5) are both 1. It follows that condition with a delay of one clock.
- R7: Issuing a trigger that was caused by a request flag clears that flag.
- R8: Writing 1 to bit k of the pending-clear register (group 6) clears pending bit k. `irq_out` falls one clock later if no enabled pending bit remains.
- R9: A rising edge that arrives while the channel's flag is already set, and is not being consumed in that cycle, sets the sticky missed bit (group 3). Writing 1 to that bit clears it.
- R10: At most one trigger is issued per cycle. Among the ready channels, the lowest channel number is issued first. A pending manual start is consumed before the flag of the same channel.
- R11: After reset all flags, enables, missed bits, pending bits and interrupt enables are 0, and `trig_valid` and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 64 | Per-channel request lines; rising edge is a request |
| reg_addr | input | 4 | Word address {group, half} |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cmpl_valid | input | 1 | Completion report valid |
| cmpl_ie | input | 1 | Completion asks for an interrupt |
| cmpl_code | input | 6 | Completion code; selects the pending bit |
| trig_valid | output | 1 | One-cycle trigger pulse |
| trig_chan | output | 6 | Channel being triggered |
| irq_out | output | 1 | Global completion interrupt |

## Verification
The bench latches a request on a disabled channel and confirms that nothing fires until the enable is written. A controller without the enable gate would trigger at once, and one that dropped the flag would never trigger. A second edge while the flag is set must raise the missed bit. Manual starts are aimed at a disabled high channel (52), which exposes a wrong half mapping or a manual path that is gated by the enable. Simultaneous requests must come out lowest first and one per cycle. A held-high line must fire only once, so a level-sensitive capture fails. On the completion side, an `cmpl_ie`=0 report must leave the pending bits alone. Interrupt enable and clear are toggled so that `irq_out` is seen both rising and falling.

// File: rtl/dei_pkg.sv
package dei_pkg;
  localparam int unsigned WORD_W = 32;

  // Register group, upper address bits; the lowest address bit(s) pick the word half.
  typedef enum logic [2:0] {
    GRP_FLAG  = 3'd0,
    GRP_EN    = 3'd1,
    GRP_START = 3'd2,
    GRP_MISS  = 3'd3,
    GRP_PEND  = 3'd4,
    GRP_IEN   = 3'd5,
    GRP_PCLR  = 3'd6
  } grp_e;
endpackage

// File: rtl/dei_evt_bank.sv
module dei_evt_bank #(
  parameter int NCH = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt_in,
  input  logic [NCH-1:0] consume,
  input  logic [NCH-1:0] miss_clr,
  output logic [NCH-1:0] flag,
  output logic [NCH-1:0] miss
);
  logic [NCH-1:0] evt_q;
  logic [NCH-1:0] rise;

  assign rise = evt_in & ~evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      flag  <= '0;
      miss  <= '0;
    end else begin
      evt_q <= evt_in;
      // a fresh edge wins over the consume of the same cycle
      flag  <= (flag & ~consume) | rise;
      miss  <= (miss & ~miss_clr) | (rise & flag & ~consume);
    end
  end
endmodule

// File: rtl/dei_trig_sched.sv
module dei_trig_sched #(
  parameter  int NCH = 64,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flag,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] start_req,
  output logic [NCH-1:0] consume_evt,
  output logic [NCH-1:0] ready,
  output logic [NCH-1:0] man,
  output logic           trig_valid,
  output logic [CHW-1:0] trig_chan
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic           any;
  logic [CHW-1:0] idx;
  logic [NCH-1:0] pick_oh;
  logic [NCH-1:0] consume_man;

  assign ready = man | (flag & en);

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        any = 1'b1;
        idx = CHW'(i);
      end
    end
  end

  assign pick_oh     = any ? (ONE << idx) : '0;
  assign consume_man = pick_oh & man;
  assign consume_evt = pick_oh & ~man;

  always_ff @(posedge clk) begin
    if (rst) begin
      man        <= '0;
      trig_valid <= 1'b0;
      trig_chan  <= '0;
    end else begin
      man        <= (man & ~consume_man) | start_req;
      trig_valid <= any;
      trig_chan  <= idx;
    end
  end
endmodule

// File: rtl/dei_irq_bank.sv
module dei_irq_bank #(
  parameter  int NCH = 64,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmpl_valid,
  input  logic           cmpl_ie,
  input  logic [CHW-1:0] cmpl_code,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] ien,
  output logic [NCH-1:0] pend,
  output logic           irq_out
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0] set_vec;

  assign set_vec = (cmpl_valid && cmpl_ie) ? (ONE << cmpl_code) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      irq_out <= 1'b0;
    end else begin
      pend    <= (pend & ~clr) | set_vec;
      irq_out <= |(pend & ien);
    end
  end
endmodule

// File: rtl/dma_evt_irq_ctrl.sv
module dma_evt_irq_ctrl
  import dei_pkg::*;
#(
  parameter  int NCH    = 64,
  localparam int CHW    = $clog2(NCH),
  localparam int HALVES = NCH / WORD_W,
  localparam int HW     = (HALVES > 1) ? $clog2(HALVES) : 1,
  localparam int AW     = 3 + HW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    evt_in,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              cmpl_valid,
  input  logic              cmpl_ie,
  input  logic [CHW-1:0]    cmpl_code,
  output logic              trig_valid,
  output logic [CHW-1:0]    trig_chan,
  output logic              irq_out
);
  grp_e           grp;
  logic [HW-1:0]  half;
  logic [NCH-1:0] wvec;
  logic [NCH-1:0] hmask;
  logic [NCH-1:0] en_q;
  logic [NCH-1:0] ien_q;
  logic [NCH-1:0] evt_flag;
  logic [NCH-1:0] miss;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] man_q;
  logic [NCH-1:0] ready;
  logic [NCH-1:0] consume_evt;
  logic [NCH-1:0] start_req;
  logic [NCH-1:0] miss_clr;
  logic [NCH-1:0] pend_clr;

  assign grp  = grp_e'(reg_addr[AW-1:HW]);
  assign half = reg_addr[HW-1:0];

  // place the bus word on the selected half of a channel-wide vector
  always_comb begin
    wvec  = '0;
    hmask = '0;
    wvec[half*WORD_W +: WORD_W]  = reg_wdata;
    hmask[half*WORD_W +: WORD_W] = '1;
  end

  assign start_req = (reg_wr && grp == GRP_START) ? wvec : '0;
  assign miss_clr  = (reg_wr && grp == GRP_MISS)  ? wvec : '0;
  assign pend_clr  = (reg_wr && grp == GRP_PCLR)  ? wvec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ien_q <= '0;
    end else if (reg_wr) begin
      if (grp == GRP_EN)  en_q  <= (en_q  & ~hmask) | wvec;
      if (grp == GRP_IEN) ien_q <= (ien_q & ~hmask) | wvec;
    end
  end

  dei_evt_bank #(.NCH(NCH)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .evt_in   (evt_in),
    .consume  (consume_evt),
    .miss_clr (miss_clr),
    .flag     (evt_flag),
    .miss     (miss)
  );

  dei_trig_sched #(.NCH(NCH)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .flag        (evt_flag),
    .en          (en_q),
    .start_req   (start_req),
    .consume_evt (consume_evt),
    .ready       (ready),
    .man         (man_q),
    .trig_valid  (trig_valid),
    .trig_chan   (trig_chan)
  );

  dei_irq_bank #(.NCH(NCH)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .cmpl_valid (cmpl_valid),
    .cmpl_ie    (cmpl_ie),
    .cmpl_code  (cmpl_code),
    .clr        (pend_clr),
    .ien        (ien_q),
    .pend       (pend),
    .irq_out    (irq_out)
  );

  // per-half word views for the read port
  logic [WORD_W-1:0] w_flag [HALVES];
  logic [WORD_W-1:0] w_en   [HALVES];
  logic [WORD_W-1:0] w_miss [HALVES];
  logic [WORD_W-1:0] w_pend [HALVES];
  logic [WORD_W-1:0] w_ien  [HALVES];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign w_flag[h] = evt_flag[h*WORD_W +: WORD_W];
    assign w_en[h]   = en_q[h*WORD_W +: WORD_W];
    assign w_miss[h] = miss[h*WORD_W +: WORD_W];
    assign w_pend[h] = pend[h*WORD_W +: WORD_W];
    assign w_ien[h]  = ien_q[h*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (grp)
        GRP_FLAG: reg_rdata <= w_flag[half];
        GRP_EN:   reg_rdata <= w_en[half];
        GRP_MISS: reg_rdata <= w_miss[half];
        GRP_PEND: reg_rdata <= w_pend[half];
        GRP_IEN:  reg_rdata <= w_ien[half];
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dei_chk.sv
module dei_chk #(
  parameter  int NCH = 64,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] evt_in,
  input logic [NCH-1:0] evt_flag,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] man_q,
  input logic [NCH-1:0] ready,
  input logic           trig_valid,
  input logic [CHW-1:0] trig_chan,
  input logic           cmpl_valid,
  input logic           cmpl_ie,
  input logic [CHW-1:0] cmpl_code,
  input logic [NCH-1:0] pend
);
  localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

  logic [NCH-1:0] in_q, rise_q, srcok_q, ready_q;
  logic           cv_q;
  logic [CHW-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      rise_q  <= '0;
      srcok_q <= '0;
      ready_q <= '0;
      cv_q    <= 1'b0;
      code_q  <= '0;
    end else begin
      in_q    <= evt_in;
      rise_q  <= evt_in & ~in_q;
      srcok_q <= en_q | man_q;
      ready_q <= ready;
      cv_q    <= cmpl_valid & cmpl_ie;
      code_q  <= cmpl_code;
    end
  end

  // R1
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise_q & ~evt_flag) == '0));

  // R2
  trig_src_chk: assert property (@(posedge clk) disable iff (rst)
    trig_valid |-> ((srcok_q & (ONE << trig_chan)) != '0));

  // R10
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    trig_valid |-> ((ready_q & ((ONE << trig_chan) - ONE)) == '0));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    cv_q |-> ((pend & (ONE << code_q)) != '0));
endmodule

bind dma_evt_irq_ctrl dei_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_in     (evt_in),
  .evt_flag   (evt_flag),
  .en_q       (en_q),
  .man_q      (man_q),
  .ready      (ready),
  .trig_valid (trig_valid),
  .trig_chan  (trig_chan),
  .cmpl_valid (cmpl_valid),
  .cmpl_ie    (cmpl_ie),
  .cmpl_code  (cmpl_code),
  .pend       (pend)
);

// File: tb/dma_evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_evt_irq_ctrl_tb;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_EVT = 3'd2, OP_CMP = 3'd3,
                         OP_TRG = 3'd4, OP_NOTRG = 3'd5, OP_IRQ = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 43;
  // addresses: flag 0/1, en 2/3, start 4/5, miss 6/7, pend 8/9, ien 10/11, pclr 12/13
  localparam vec_t VT [NV] = '{
    '{OP_EVT,  4'd0,  32'h8,      32'h0,      8'd1},  // R1 edge on disabled ch3
    '{OP_RD,   4'd0,  32'h0,      32'h8,      8'd1},  // R1
    '{OP_NOTRG,4'd0,  32'h0,      32'h0,      8'd2},  // R2 no trigger while disabled
    '{OP_EVT,  4'd0,  32'h8,      32'h0,      8'd9},  // R9 second edge
    '{OP_RD,   4'd6,  32'h0,      32'h8,      8'd9},  // R9
    '{OP_RD,   4'd0,  32'h0,      32'h8,      8'd2},  // R2 flag kept
    '{OP_WR,   4'd2,  32'h8,      32'h0,      8'd2},  // R2 enable ch3
    '{OP_TRG,  4'd0,  32'h0,      32'd3,      8'd2},  // R2
    '{OP_RD,   4'd0,  32'h0,      32'h0,      8'd7},  // R7 flag cleared
    '{OP_WR,   4'd6,  32'h8,      32'h0,      8'd9},  // R9 clear
    '{OP_RD,   4'd6,  32'h0,      32'h0,      8'd9},  // R9
    '{OP_WR,   4'd5,  32'h0010_0000, 32'h0,   8'd3},  // R3 manual ch52
    '{OP_TRG,  4'd0,  32'h0,      32'd52,     8'd3},  // R3
    '{OP_RD,   4'd1,  32'h0,      32'h0,      8'd3},  // R3 flag untouched
    '{OP_EVT,  4'd1,  32'h0010_0000, 32'h0,   8'd4},  // R4 edge ch52
    '{OP_RD,   4'd1,  32'h0,      32'h0010_0000, 8'd4}, // R4
    '{OP_NOTRG,4'd0,  32'h0,      32'h0,      8'd4},  // R4
    '{OP_WR,   4'd3,  32'h0010_0000, 32'h0,   8'd4},  // R4 enable ch52
    '{OP_TRG,  4'd0,  32'h0,      32'd52,     8'd4},  // R4
    '{OP_RD,   4'd1,  32'h0,      32'h0,      8'd7},  // R7
    '{OP_WR,   4'd2,  32'hF0,     32'h0,      8'd10}, // R10 enable ch4..7
    '{OP_EVT,  4'd0,  32'hA0,     32'h0,      8'd10}, // R10 ch5 and ch7 together
    '{OP_TRG,  4'd0,  32'h0,      32'd5,      8'd10}, // R10
    '{OP_TRG,  4'd0,  32'h0,      32'd7,      8'd10}, // R10
    '{OP_WR,   4'd4,  32'h6,      32'h0,      8'd10}, // R10 manual ch1,ch2
    '{OP_TRG,  4'd0,  32'h0,      32'd1,      8'd10}, // R10
    '{OP_TRG,  4'd0,  32'h0,      32'd2,      8'd10}, // R10
    '{OP_CMP,  4'd0,  32'h128,    32'h0,      8'd5},  // R5 code 40 with ie
    '{OP_IRQ,  4'd0,  32'h0,      32'h0,      8'd6},  // R6 not enabled
    '{OP_RD,   4'd9,  32'h0,      32'h100,    8'd5},  // R5 bit 8 of high word
    '{OP_WR,   4'd11, 32'h100,    32'h0,      8'd6},  // R6
    '{OP_IRQ,  4'd0,  32'h0,      32'h1,      8'd6},  // R6
    '{OP_CMP,  4'd0,  32'h002,    32'h0,      8'd5},  // R5 ie=0 ignored
    '{OP_RD,   4'd8,  32'h0,      32'h0,      8'd5},  // R5
    '{OP_WR,   4'd13, 32'h100,    32'h0,      8'd8},  // R8 clear code 40
    '{OP_IRQ,  4'd0,  32'h0,      32'h0,      8'd8},  // R8
    '{OP_RD,   4'd9,  32'h0,      32'h0,      8'd8},  // R8
    '{OP_CMP,  4'd0,  32'h102,    32'h0,      8'd5},  // R5 code 2 with ie
    '{OP_RD,   4'd8,  32'h0,      32'h4,      8'd5},  // R5
    '{OP_IRQ,  4'd0,  32'h0,      32'h0,      8'd6},  // R6
    '{OP_WR,   4'd10, 32'h4,      32'h0,      8'd6},  // R6
    '{OP_IRQ,  4'd0,  32'h0,      32'h1,      8'd6},  // R6
    '{OP_WR,   4'd10, 32'h0,      32'h0,      8'd6}   // R6 mask again
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] evt_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmpl_valid = 1'b0;
  logic        cmpl_ie = 1'b0;
  logic [5:0]  cmpl_code = '0;
  logic        trig_valid;
  logic [5:0]  trig_chan;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int log_wr = 0;
  int log_rd = 0;
  logic [5:0] tlog [256];

  always #2 clk = ~clk;

  dma_evt_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmpl_valid(cmpl_valid),
    .cmpl_ie(cmpl_ie), .cmpl_code(cmpl_code), .trig_valid(trig_valid),
    .trig_chan(trig_chan), .irq_out(irq_out)
  );

  // trigger monitor: one sample per cycle, away from the active edge
  initial forever begin
    @(negedge clk);
    if (!rst && trig_valid && log_wr < 256) begin
      tlog[log_wr] = trig_chan;
      log_wr++;
    end
  end

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] e, input int req);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata == e, req, reg_rdata, e);
  endtask

  task automatic do_evt(input logic [3:0] a, input logic [31:0] m);
    evt_in = '0;
    evt_in[a[0]*32 +: 32] = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic do_cmp(input logic [31:0] d);
    cmpl_valid = 1'b1; cmpl_code = d[5:0]; cmpl_ie = d[8];
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_ie = 1'b0;
  endtask

  task automatic do_trg(input logic [31:0] e, input int req);
    repeat (2) @(negedge clk);
    #1;
    if (log_rd < log_wr) begin
      check(tlog[log_rd] == e[5:0], req, 32'(tlog[log_rd]), e);
      log_rd++;
    end else begin
      check(1'b0, req, 32'hFFFF_FFFF, e);
    end
  endtask

  task automatic do_notrg(input int req);
    repeat (3) @(negedge clk);
    #1;
    check(log_rd == log_wr, req, 32'(log_wr - log_rd), 32'd0);
    log_rd = log_wr;
  endtask

  task automatic do_irq(input logic [31:0] e, input int req);
    @(negedge clk);
    check(irq_out == e[0], req, 32'(irq_out), e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(trig_valid == 1'b0, 11, 32'(trig_valid), 32'd0);
    check(irq_out == 1'b0, 11, 32'(irq_out), 32'd0);
    do_rd(4'd2, 32'h0, 11);
    do_rd(4'd9, 32'h0, 11);

    for (int i = 0; i < NV; i++) begin
      case (VT[i].op)
        OP_WR:    do_wr(VT[i].addr, VT[i].data);
        OP_RD:    do_rd(VT[i].addr, VT[i].exp, int'(VT[i].req));
        OP_EVT:   do_evt(VT[i].addr, VT[i].data);
        OP_CMP:   do_cmp(VT[i].data);
        OP_TRG:   do_trg(VT[i].exp, int'(VT[i].req));
        OP_NOTRG: do_notrg(int'(VT[i].req));
        default:  do_irq(VT[i].exp, int'(VT[i].req));
      endcase
    end

    // R1 a line held high requests once (ch4 is enabled)
    evt_in[4] = 1'b1;
    repeat (5) @(negedge clk);
    evt_in[4] = 1'b0;
    #1;
    check(log_wr - log_rd == 1, 1, 32'(log_wr - log_rd), 32'd1);
    if (log_rd < log_wr) check(tlog[log_rd] == 6'd4, 1, 32'(tlog[log_rd]), 32'd4);
    log_rd = log_wr;
    do_notrg(1);

    // R11 reset mid-run clears pending, enables and interrupt
    do_cmp(32'h100);
    do_wr(4'd10, 32'h1);
    do_irq(32'h1, 6);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(irq_out == 1'b0, 11, 32'(irq_out), 32'd0);
    do_rd(4'd8, 32'h0, 11);
    do_rd(4'd10, 32'h0, 11);
    do_rd(4'd2, 32'h0, 11);
    finish_run();
  end
endmodule